// File: doc/BRIEF.md
# Configuration Memory Column Parity Monitor

This block guards a small non-volatile configuration store that holds protection thresholds, delay settings and trim words. After reset it reads the store one word at a time. For every bit column it keeps a running XOR across all data words. It then reads a stored parity row that was written together with the data and compares the two. A difference in any column latches a permanent fault. The block then waits a fixed number of idle cycles and starts the next pass, so the scan repeats for as long as the block is out of reset.

The store itself sits outside the block. The block drives an address and a read enable, and the word at that address comes back combinationally on `mem_data`. The way the block reacts to a fault depends on the operating-mode input. When a supervising host is in control, the block only sets the fault flag and pulls the active-low alert low, and the gate and open-drain requests from the host reach the pins unchanged. In stand-alone operation, a fault also drives both FET gate outputs high, which turns both FETs off, and it disables the general-purpose open-drain output.

Top module: `cfg_parity_monitor`

## Requirements
- R1: While reset is asserted and right after it is released, `fault_flag` is 0 and `alert_n` is 1. The three pin outputs follow the host request inputs.
- R2: Each pass holds `mem_en` at 1 while it presents addresses 0 up to NUM_WORDS-1 in ascending order, one per cycle. The parity row at address NUM_WORDS comes last. `mem_en` then stays 0 for GAP_CYCLES cycles, so a pass lasts NUM_WORDS+1+GAP_CYCLES cycles. The first functional clock edge is the third edge after `rst_n` rises.
- R3: Parity is computed per bit column: bit c of the parity row must equal the XOR of bit c of every data word. A mismatch in any column is a fault, and this includes a flipped bit in the parity row itself. Two flips in the same column of two data words cancel and are not detected.
- R4: `fault_flag` rises on the clock edge that reads the parity row of a pass that mismatches. A word changed during the idle gap is seen by the next pass.
- R5: `alert_n` is the inverse of `fault_flag` in every cycle.
- R6: Once set, `fault_flag` stays 1 until reset, even after later passes match. Reset clears it.
- R7: In stand-alone mode (`host_mode`=0) with the fault set, `dsg_gate`=1 and `chg_gate`=1, so both FETs are off, and `gpod_en`=0, whatever the host requests are.
- R8: In host-control mode (`host_mode`=1) with the fault set, `dsg_gate`, `chg_gate` and `gpod_en` equal `host_dsg_off`, `host_chg_off` and `host_gpod_en`. Only the fault flag and the alert change.
- R9: With no fault, in either mode, the three pin outputs equal the host request inputs in the same cycle.
- R10: `host_mode` is read continuously. Switching from host-control to stand-alone while the fault is set applies the forced response in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_mode | input | 1 | 1 = host-control, 0 = stand-alone |
| mem_data | input | DATA_W | Word at `mem_addr`, returned combinationally |
| host_dsg_off | input | 1 | Request to turn the discharge FET off (high = off) |
| host_chg_off | input | 1 | Request to turn the charge FET off (high = off) |
| host_gpod_en | input | 1 | Request to enable the general-purpose open-drain output |
| mem_en | output | 1 | Read enable for the configuration store |
| mem_addr | output | ADDR_W | Read address; NUM_WORDS selects the parity row |
| fault_flag | output | 1 | Permanent-fault bit of the output-control register |
| alert_n | output | 1 | Active-low alert |
| dsg_gate | output | 1 | Discharge FET gate drive (high = FET off) |
| chg_gate | output | 1 | Charge FET gate drive (high = FET off) |
| gpod_en | output | 1 | General-purpose open-drain output enable |

## Verification
The first functional edge comes two edges after reset release, because of the reset synchronizer. Address k of pass m is therefore presented in cycle 2+m*49+k, and a mismatch in pass m shows on `fault_flag` and `alert_n` in cycle 19+m*49, with 16 words and a 32-cycle gap. The pin outputs are combinational on the mode and request inputs, so a change there is due in the same cycle. The bench counts cycles from reset release and drives its inputs and memory edits 5 ns after a falling edge. It queues the expected output set with the exact cycle number, and the monitor compares that set at the falling edge of that cycle. Each fault case is paired with a check one cycle earlier that the flag is still clear.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

  typedef enum logic {
    ST_SCAN = 1'b0,
    ST_GAP  = 1'b1
  } scan_state_t;

endpackage

// File: rtl/cpm_rst_sync.sv
module cpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= 1'b0;
        end else begin
          if (s == 0) stage_q[s] <= 1'b1;
          else        stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
        end
      end
    end
  endgenerate

  assign rst_sync_n = stage_q[STAGES-1];

endmodule

// File: rtl/cpm_scan_seq.sv
module cpm_scan_seq
  import cpm_pkg::*;
#(
  parameter int NUM_WORDS  = 16,
  parameter int GAP_CYCLES = 32,
  localparam int ADDR_W    = $clog2(NUM_WORDS + 1),
  localparam int CNT_W     = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              word_vld,
  output logic              row_vld
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_WORDS);
  localparam logic [CNT_W-1:0]  GAP_LOAD  = CNT_W'(GAP_CYCLES - 1);

  scan_state_t       state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_SCAN: begin
        if (addr_q == LAST_ADDR) begin
          state_d = ST_GAP;
          addr_d  = '0;
          cnt_d   = GAP_LOAD;
        end else begin
          addr_d = addr_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt_q == '0) begin
          state_d = ST_SCAN;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SCAN;
      addr_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
    end
  end

  assign mem_en   = (state_q == ST_SCAN);
  assign mem_addr = addr_q;
  assign row_vld  = mem_en && (addr_q == LAST_ADDR);
  assign word_vld = mem_en && (addr_q != LAST_ADDR);

endmodule

// File: rtl/cpm_col_parity.sv
module cpm_col_parity #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic              row_vld,
  input  logic [DATA_W-1:0] mem_data,
  output logic              mismatch
);

  logic [DATA_W-1:0] acc_q, acc_d, col_diff;
  logic              acc_en;

  assign acc_en = word_vld | row_vld;

  generate
    for (genvar c = 0; c < DATA_W; c++) begin : g_col
      always_comb begin
        col_diff[c] = acc_q[c] ^ mem_data[c];
        acc_d[c]    = row_vld ? 1'b0 : col_diff[c];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acc_q[c] <= 1'b0;
        end else if (acc_en) begin
          acc_q[c] <= acc_d[c];
        end
      end
    end
  endgenerate

  assign mismatch = row_vld && (|col_diff);

endmodule

// File: rtl/cpm_fault_resp.sv
module cpm_fault_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic mismatch,
  input  logic host_mode,
  input  logic host_dsg_off,
  input  logic host_chg_off,
  input  logic host_gpod_en,
  output logic fault_flag,
  output logic alert_n,
  output logic dsg_gate,
  output logic chg_gate,
  output logic gpod_en
);

  logic fault_q, fault_d, fault_en;
  logic force_off;

  always_comb begin
    fault_en = mismatch & ~fault_q;
    fault_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
    end else if (fault_en) begin
      fault_q <= fault_d;
    end
  end

  always_comb begin
    force_off  = fault_q & ~host_mode;
    fault_flag = fault_q;
    alert_n    = ~fault_q;
    dsg_gate   = host_dsg_off | force_off;
    chg_gate   = host_chg_off | force_off;
    gpod_en    = host_gpod_en & ~force_off;
  end

endmodule

// File: rtl/cfg_parity_monitor.sv
module cfg_parity_monitor #(
  parameter int DATA_W      = 8,
  parameter int NUM_WORDS   = 16,
  parameter int GAP_CYCLES  = 32,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(NUM_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_mode,
  input  logic [DATA_W-1:0] mem_data,
  input  logic              host_dsg_off,
  input  logic              host_chg_off,
  input  logic              host_gpod_en,
  output logic              mem_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              fault_flag,
  output logic              alert_n,
  output logic              dsg_gate,
  output logic              chg_gate,
  output logic              gpod_en
);

  logic rst_sync_n;
  logic word_vld, row_vld, mismatch;

  cpm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cpm_scan_seq #(.NUM_WORDS(NUM_WORDS), .GAP_CYCLES(GAP_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .mem_en   (mem_en),
    .mem_addr (mem_addr),
    .word_vld (word_vld),
    .row_vld  (row_vld)
  );

  cpm_col_parity #(.DATA_W(DATA_W)) u_par (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .word_vld (word_vld),
    .row_vld  (row_vld),
    .mem_data (mem_data),
    .mismatch (mismatch)
  );

  cpm_fault_resp u_resp (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .mismatch     (mismatch),
    .host_mode    (host_mode),
    .host_dsg_off (host_dsg_off),
    .host_chg_off (host_chg_off),
    .host_gpod_en (host_gpod_en),
    .fault_flag   (fault_flag),
    .alert_n      (alert_n),
    .dsg_gate     (dsg_gate),
    .chg_gate     (chg_gate),
    .gpod_en      (gpod_en)
  );

endmodule

// File: rtl/cfg_parity_monitor_chk.sv
module cfg_parity_monitor_chk #(
  parameter int NUM_WORDS = 16,
  parameter int ADDR_W    = 5
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              host_mode,
  input logic              host_dsg_off,
  input logic              host_chg_off,
  input logic              host_gpod_en,
  input logic              mem_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              fault_flag,
  input logic              alert_n,
  input logic              dsg_gate,
  input logic              chg_gate,
  input logic              gpod_en
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_WORDS);

  // R2: addresses never run past the parity row
  a_r2_addr_range: assert property (@(posedge clk) disable iff (!rst_ok)
    mem_en |-> (mem_addr <= LAST_ADDR));

  // R2: data addresses advance by one each cycle
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_ok)
    (mem_en && mem_addr != LAST_ADDR) |=> (mem_en && mem_addr == $past(mem_addr) + 1'b1));

  // R4: fault only rises right after the parity row was read
  a_r4_rise_on_row: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(fault_flag) |-> $past(mem_en && mem_addr == LAST_ADDR));

  // R5: alert is the inverse of the fault bit
  a_r5_alert_tracks: assert property (@(posedge clk) disable iff (!rst_ok)
    alert_n != fault_flag);

  // R6: fault is sticky
  a_r6_fault_sticky: assert property (@(posedge clk) disable iff (!rst_ok)
    fault_flag |=> fault_flag);

  // R7: stand-alone fault forces FETs off and open-drain off
  a_r7_standalone_force: assert property (@(posedge clk) disable iff (!rst_ok)
    (fault_flag && !host_mode) |-> (dsg_gate && chg_gate && !gpod_en));

  // R8 / R9: otherwise the pins follow the host requests
  a_r8_host_follow: assert property (@(posedge clk) disable iff (!rst_ok)
    (host_mode || !fault_flag) |->
      (dsg_gate == host_dsg_off && chg_gate == host_chg_off && gpod_en == host_gpod_en));

endmodule

bind cfg_parity_monitor cfg_parity_monitor_chk #(
  .NUM_WORDS (NUM_WORDS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_ok       (rst_sync_n),
  .host_mode    (host_mode),
  .host_dsg_off (host_dsg_off),
  .host_chg_off (host_chg_off),
  .host_gpod_en (host_gpod_en),
  .mem_en       (mem_en),
  .mem_addr     (mem_addr),
  .fault_flag   (fault_flag),
  .alert_n      (alert_n),
  .dsg_gate     (dsg_gate),
  .chg_gate     (chg_gate),
  .gpod_en      (gpod_en)
);

// File: tb/cfg_parity_monitor_tb.sv
module cfg_parity_monitor_tb;

  localparam int DW  = 8;
  localparam int NW  = 16;
  localparam int GAP = 32;
  localparam int AW  = $clog2(NW + 1);
  localparam int OFS = 2;
  localparam int PER = NW + 1 + GAP;

  logic          clk;
  logic          rst_n;
  logic          host_mode;
  logic [DW-1:0] mem_data;
  logic          host_dsg_off, host_chg_off, host_gpod_en;
  logic          mem_en;
  logic [AW-1:0] mem_addr;
  logic          fault_flag, alert_n, dsg_gate, chg_gate, gpod_en;

  logic [DW-1:0] mem [0:NW];
  int cyc;
  int checks;
  int failures;

  typedef struct {
    int         at;
    logic [4:0] outs;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  cfg_parity_monitor #(.DATA_W(DW), .NUM_WORDS(NW), .GAP_CYCLES(GAP)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_mode    (host_mode),
    .mem_data     (mem_data),
    .host_dsg_off (host_dsg_off),
    .host_chg_off (host_chg_off),
    .host_gpod_en (host_gpod_en),
    .mem_en       (mem_en),
    .mem_addr     (mem_addr),
    .fault_flag   (fault_flag),
    .alert_n      (alert_n),
    .dsg_gate     (dsg_gate),
    .chg_gate     (chg_gate),
    .gpod_en      (gpod_en)
  );

  assign mem_data = (int'(mem_addr) <= NW) ? mem[mem_addr] : '0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int cmp_cyc(int m);
    return OFS + NW + 1 + m * PER;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // driver side: queue the expected {fault, alert_n, dsg, chg, gpod}
  task automatic expect_at(int at, logic f, logic a, logic d, logic c, logic g, string tag);
    exp_t e;
    e.at = at; e.outs = {f, a, d, c, g}; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_cyc(int n);
    do @(negedge clk); while (cyc != n);
    #5;
  endtask

  // monitor: compare at the falling edge of the expected cycle
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
      exp_t e;
      logic [4:0] act;
      e = exp_q.pop_front();
      act = {fault_flag, alert_n, dsg_gate, chg_gate, gpod_en};
      check(e.at == cyc && act === e.outs, e.tag, int'(act), int'(e.outs));
    end
  end

  task automatic fill_mem();
    logic [DW-1:0] par;
    par = '0;
    for (int i = 0; i < NW; i++) begin
      mem[i] = DW'(i * 37 + 11);
      par    = par ^ mem[i];
    end
    mem[NW] = par;
  endtask

  task automatic do_reset();
    @(negedge clk);
    #5 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc   = 0;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0; cyc = 0;
    rst_n = 1'b0;
    host_mode = 1'b0; host_dsg_off = 1'b0; host_chg_off = 1'b0; host_gpod_en = 1'b1;
    fill_mem();
    repeat (2) @(negedge clk);
    do_reset();

    // R1: reset state, outputs follow host
    expect_at(1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R1 reset state");
    // R3: clean memory gives no fault at pass 1 end
    expect_at(cmp_cyc(1), 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R3 clean pass");

    // R2: address and enable pattern over the first passes
    for (int n = 2; n <= 70; n++) begin
      int t, k;
      wait_cyc(n);
      t = n - 5 - OFS; // sampled at negedge n, wait_cyc lands 5 ns later
      t = n - OFS;
      k = t % PER;
      check(mem_en === (k <= NW), "R2 mem_en", int'(mem_en), int'(k <= NW));
      if (k <= NW) check(int'(mem_addr) == k, "R2 mem_addr", int'(mem_addr), k);
    end

    // R9: no fault, stand-alone, pins follow host
    wait_cyc(72);
    host_dsg_off = 1'b1; host_chg_off = 1'b0; host_gpod_en = 1'b0;
    expect_at(73, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9 stand-alone follow");
    wait_cyc(74);
    host_mode = 1'b1; host_dsg_off = 1'b0; host_chg_off = 1'b1; host_gpod_en = 1'b1;
    expect_at(75, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R9 host follow");

    // R3: two flips in the same column cancel
    wait_cyc(80);
    mem[2][3] = ~mem[2][3];
    mem[5][3] = ~mem[5][3];
    expect_at(cmp_cyc(2), 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R3 same-column pair undetected");

    // R4/R5/R8: single flip detected in host mode
    wait_cyc(cmp_cyc(2) + 8);
    mem[5][3] = ~mem[5][3];
    expect_at(cmp_cyc(3) - 1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R4 not before row read");
    expect_at(cmp_cyc(3), 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R4 R5 R8 fault in host mode");
    wait_cyc(cmp_cyc(3) + 4);
    host_dsg_off = 1'b1; host_chg_off = 1'b0; host_gpod_en = 1'b0;
    expect_at(cmp_cyc(3) + 5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R8 host keeps pin control");
    wait_cyc(cmp_cyc(3) + 6);
    host_mode = 1'b0;
    expect_at(cmp_cyc(3) + 7, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R10 R7 mode switch forces off");
    wait_cyc(cmp_cyc(3) + 8);
    host_dsg_off = 1'b0; host_chg_off = 1'b0; host_gpod_en = 1'b1;
    expect_at(cmp_cyc(3) + 9, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R7 forced despite host");

    // R6: restore memory, fault stays
    wait_cyc(cmp_cyc(3) + 10);
    mem[2][3] = ~mem[2][3];
    expect_at(cmp_cyc(5) + 2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R6 sticky after clean passes");
    wait_cyc(cmp_cyc(5) + 4);

    // R6 / R1: reset clears the fault
    do_reset();
    expect_at(1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R6 R1 reset clears fault");

    // R3/R7: parity-row flip in stand-alone mode
    wait_cyc(5);
    mem[NW][6] = ~mem[NW][6];
    expect_at(cmp_cyc(0) - 1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R4 not before row read");
    expect_at(cmp_cyc(0), 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R3 R7 parity row flip stand-alone");
    wait_cyc(cmp_cyc(0) + 4);
    mem[NW][6] = ~mem[NW][6];

    // R3: flips in two different columns are detected
    do_reset();
    host_mode = 1'b1;
    wait_cyc(cmp_cyc(0) + 2);
    mem[1][0] = ~mem[1][0];
    mem[9][6] = ~mem[9][6];
    expect_at(cmp_cyc(1) - 1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R4 not before row read");
    expect_at(cmp_cyc(1), 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R3 two columns detected");
    wait_cyc(cmp_cyc(1) + 3);

    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule